// File: doc/BRIEF.md
# Chunk-Keyed Operand Bit Restorer

This block sits directly after instruction fetch in a processor whose program image has its instruction operands scrambled. Each fetched 32-bit word has a 6-bit opcode and a 26-bit operand. The operand's bits have been reordered by a fixed pseudo-random permutation. Program memory is divided into equal power-of-two chunks, and each chunk uses its own permutation. The block takes the program counter, the scrambled 26-bit operand and a pass-through flag from the opcode decoder. One clock later it presents the native operand.

The permutation used for an instruction is chosen by its word address. The chunk index is read from the program-counter bits just above the chunk offset. Only as many bits are used as are needed to address the configured number of permutations, so chunks beyond the last permutation reuse the tables cyclically.

The permutations are fixed when the design is elaborated. They are generated from a seed parameter by a deterministic shuffle. The number of permutations may be 1, 2, 4 or 8.

Instructions that are never scrambled have the pass-through flag set, and their operand is forwarded unchanged. These are control flow, sleep and interface transfer instructions.

Downstream logic splits the restored operand into fields. For R-type words these are three 5-bit register numbers, a 5-bit shift amount and a 6-bit function code. For I-type words they are two 5-bit registers and a 16-bit immediate. For J-type words the whole operand is a 26-bit target.

Top module: `opnd_restore`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `opnd_out` is all zeros.
- R2: `opnd_out` is registered. A value presented at a rising edge appears on `opnd_out` just after that edge, and not earlier.
- R3: With `pass_thru` low, `opnd_out` equals the inverse of permutation number c applied to `opnd_in`. The chunk number c is `pc[2+CHUNK_LOG2 +: log2(NUM_PERM)]`, which is 0 when NUM_PERM is 1. Forward permutation c maps native bit `map_c[i]` to scrambled bit i.
- R4: With `pass_thru` high, `opnd_out` equals `opnd_in` bit for bit, whatever the value of `pc`.
- R5: `pc[1:0]`, the word-offset bits `pc[CHUNK_LOG2+1:2]` and every bit above the chunk-number field have no effect on the result.
- R6: Every table is a bijection of the 26 bit positions. The output has the same number of set bits as the input, and an all-zero input gives an all-zero output.
- R7: Once restored, the R-type function code appears at `opnd_out[5:0]`, the shift amount at [10:6] and the 16-bit immediate at [15:0], even when those bits were spread across the scrambled operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pc | input | PC_W | Byte address of the fetched instruction |
| opnd_in | input | 26 | Scrambled operand field of the instruction |
| pass_thru | input | 1 | High for instructions whose operand is not scrambled |
| opnd_out | output | 26 | Restored native operand, one cycle after the inputs |

## Verification
On every cycle, the assertions check the following:
- the pass-through path is exact;
- the number of set bits is preserved across any table;
- a zero operand stays zero;
- each generated table is a true bijection at elaboration.

Only the bench scenarios can show that the right table is picked for each chunk. For this, the bench feeds operands it scrambled itself with the forward tables. The same scenarios cover:
- chunk index wrap-around;
- insensitivity to the offset and low address bits;
- the registered latency;
- the function-code and immediate fields landing back in their native positions.

// File: rtl/opnd_restore_pkg.sv
package opnd_restore_pkg;
   localparam int OPND_W = 26;
   localparam int IDX_W  = 5;

   typedef logic [IDX_W-1:0]        idx_t;
   typedef idx_t [OPND_W-1:0]       map_t;

   // Forward table for chunk k: scrambled bit i carries native bit map[i].
   // A seeded xorshift drives a Fisher-Yates shuffle of the positions.
   function automatic map_t fwd_map(input int unsigned k, input int unsigned seed);
      map_t        m;
      idx_t        tmp;
      int unsigned s;
      int unsigned j;
      for (int i = 0; i < OPND_W; i++) m[i] = idx_t'(i);
      s = seed ^ (k * 32'h9E37_79B9) ^ 32'h5bd1_e995;
      if (s == 0) s = 32'h1;
      for (int i = OPND_W - 1; i > 0; i--) begin
         s = s ^ (s << 13);
         s = s ^ (s >> 17);
         s = s ^ (s << 5);
         j = s % (i + 1);
         tmp  = m[i];
         m[i] = m[j];
         m[j] = tmp;
      end
      return m;
   endfunction
endpackage

// File: rtl/opnd_chunk_sel.sv
module opnd_chunk_sel #(
   parameter int PC_W       = 32,
   parameter int CHUNK_LOG2 = 4,
   parameter int NUM_PERM   = 4,
   localparam int SEL_W     = (NUM_PERM > 1) ? $clog2(NUM_PERM) : 1
) (
   input  logic [PC_W-1:0]  pc,
   output logic [SEL_W-1:0] chunk
);
   localparam int LSB = 2 + CHUNK_LOG2;

   generate
      if (NUM_PERM == 1) begin : g_single
         logic unused_pc;
         assign unused_pc = ^pc;
         assign chunk     = '0;
      end else begin : g_multi
         logic [LSB-1:0]          unused_lo;
         logic [PC_W-LSB-SEL_W:0] unused_hi;
         assign unused_lo = pc[LSB-1:0];
         assign unused_hi = {1'b0, pc[PC_W-1:LSB+SEL_W]};
         assign chunk     = pc[LSB +: SEL_W];
      end
   endgenerate
endmodule

// File: rtl/opnd_inv_net.sv
module opnd_inv_net
   import opnd_restore_pkg::*;
#(
   parameter int unsigned IDX  = 0,
   parameter int unsigned SEED = 32'h1234_5678
) (
   input  logic [OPND_W-1:0] scr_in,
   output logic [OPND_W-1:0] nat_out
);
   localparam map_t MAP = fwd_map(IDX, SEED);

   always_comb begin
      nat_out = '0;
      for (int i = 0; i < OPND_W; i++) nat_out[MAP[i]] = scr_in[i];
   end

   // R6: the generated table must hit every position exactly once
   initial begin
      logic [OPND_W-1:0] hit;
      hit = '0;
      for (int i = 0; i < OPND_W; i++) hit[MAP[i]] = 1'b1;
      AST_MAP_BIJECTIVE: assert (&hit) else $error("table %0d not a permutation", IDX); // R6
   end
endmodule

// File: rtl/opnd_restore.sv
module opnd_restore
   import opnd_restore_pkg::*;
#(
   parameter int          PC_W       = 32,
   parameter int          CHUNK_LOG2 = 4,
   parameter int          NUM_PERM   = 4,
   parameter int unsigned PERM_SEED  = 32'hC0DE_5EED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   pc,
   input  logic [OPND_W-1:0] opnd_in,
   input  logic              pass_thru,
   output logic [OPND_W-1:0] opnd_out
);
   localparam int SEL_W = (NUM_PERM > 1) ? $clog2(NUM_PERM) : 1;

   // elaboration checks
   generate
      if (!(NUM_PERM == 1 || NUM_PERM == 2 || NUM_PERM == 4 || NUM_PERM == 8)) begin : g_bad_num
         $error("NUM_PERM must be 1, 2, 4 or 8");
      end
      if (PC_W < 2 + CHUNK_LOG2 + SEL_W) begin : g_bad_pcw
         $error("PC_W too narrow for chunk field");
      end
      if (CHUNK_LOG2 < 0) begin : g_bad_chunk
         $error("CHUNK_LOG2 must be non-negative");
      end
   endgenerate

   logic [SEL_W-1:0]  chunk;
   logic [OPND_W-1:0] nat [NUM_PERM];
   logic [OPND_W-1:0] picked;
   logic [OPND_W-1:0] opnd_q;
   logic              primed_q;

   opnd_chunk_sel #(
      .PC_W       (PC_W),
      .CHUNK_LOG2 (CHUNK_LOG2),
      .NUM_PERM   (NUM_PERM)
   ) u_sel (
      .pc    (pc),
      .chunk (chunk)
   );

   generate
      for (genvar g = 0; g < NUM_PERM; g++) begin : g_net
         opnd_inv_net #(
            .IDX  (g),
            .SEED (PERM_SEED)
         ) u_net (
            .scr_in  (opnd_in),
            .nat_out (nat[g])
         );
      end
   endgenerate

   always_comb begin
      picked = nat[0];
      for (int k = 1; k < NUM_PERM; k++)
         if (chunk == SEL_W'(k)) picked = nat[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         opnd_q   <= '0;
         primed_q <= 1'b0;
      end else begin
         opnd_q   <= pass_thru ? opnd_in : picked;
         primed_q <= 1'b1;
      end
   end

   assign opnd_out = opnd_q;

   AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && $past(pass_thru)) |-> (opnd_out == $past(opnd_in))); // R4
   AST_ONES_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      primed_q |-> ($countones(opnd_out) == $countones($past(opnd_in)))); // R6
   AST_ZERO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && ($past(opnd_in) == '0)) |-> (opnd_out == '0)); // R6
   AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !primed_q |-> (opnd_out == '0)); // R1
endmodule

// File: tb/opnd_restore_tb.sv
module opnd_restore_tb;
   import opnd_restore_pkg::*;

   localparam int          PC_W  = 32;
   localparam int          CL    = 4;
   localparam int          NP    = 4;
   localparam int unsigned SEED  = 32'hC0DE_5EED;

   typedef struct {
      logic [OPND_W-1:0] exp;
      string             tag;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [PC_W-1:0]   pc = '0;
   logic [OPND_W-1:0] opnd_in = '0;
   logic              pass_thru = 1'b0;
   logic [OPND_W-1:0] opnd_out;

   int     checks = 0;
   int     errors = 0;
   item_t  sb[$];
   logic   mon_en = 1'b0;
   logic   done = 1'b0;

   always #5 clk = ~clk;

   opnd_restore #(
      .PC_W       (PC_W),
      .CHUNK_LOG2 (CL),
      .NUM_PERM   (NP),
      .PERM_SEED  (SEED)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pc        (pc),
      .opnd_in   (opnd_in),
      .pass_thru (pass_thru),
      .opnd_out  (opnd_out)
   );

   function automatic logic [OPND_W-1:0] scramble(input logic [OPND_W-1:0] n, input int k);
      map_t m = fwd_map(k, SEED);
      logic [OPND_W-1:0] p;
      for (int i = 0; i < OPND_W; i++) p[i] = n[m[i]];
      return p;
   endfunction

   task automatic check(input logic [OPND_W-1:0] act, input logic [OPND_W-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // driver: one item per cycle, driven at the falling edge
   task automatic drive(input logic [PC_W-1:0] a, input logic [OPND_W-1:0] op,
                        input logic byp, input logic [OPND_W-1:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      pc = a; opnd_in = op; pass_thru = byp;
      it.exp = exp; it.tag = tag;
      sb.push_back(it);
   endtask

   function automatic logic [PC_W-1:0] mk_pc(input int k, input logic [PC_W-1:0] hi_rand);
      logic [PC_W-1:0] a;
      a = hi_rand;
      a[2+CL +: 2] = 2'(k);
      return a;
   endfunction

   // monitor
   always @(posedge clk) begin
      #2;
      if (mon_en && sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         check(opnd_out, it.exp, it.tag);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [OPND_W-1:0] n;
      logic [OPND_W-1:0] last;
      // R1: reset clears output even with a live operand
      opnd_in = 26'h3ff_ffff; pc = 32'h40;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(opnd_out, '0, "R1 during reset");
      rst_n = 1'b1;
      opnd_in = '0;
      @(negedge clk);
      check(opnd_out, '0, "R1 after release");
      mon_en = 1'b1;

      // R4: pass-through with assorted pc values
      for (int t = 0; t < 20; t++) begin
         n = OPND_W'($urandom);
         drive($urandom, n, 1'b1, n, "R4 pass_thru");
      end

      // R3: every chunk, random operands scrambled by forward table
      for (int k = 0; k < NP; k++)
         for (int t = 0; t < 25; t++) begin
            n = OPND_W'($urandom);
            drive(mk_pc(k, 32'(k) << (2 + CL)) | 32'($urandom_range(0, (1 << (2 + CL)) - 1)),
                  scramble(n, k), 1'b0, n, "R3 chunk restore");
         end

      // R5: high bits, word offset and byte bits ignored; wrap-around
      for (int t = 0; t < 40; t++) begin
         int k = $urandom_range(0, NP - 1);
         n = OPND_W'($urandom);
         drive(mk_pc(k, $urandom), scramble(n, k), 1'b0, n, "R5 address bits ignored");
      end

      // R6: single bits and zero
      for (int b = 0; b < OPND_W; b++) begin
         int k = b % NP;
         n = OPND_W'(1) << b;
         drive(mk_pc(k, $urandom), scramble(n, k), 1'b0, n, "R6 one-hot");
      end
      drive(mk_pc(2, $urandom), '0, 1'b0, '0, "R6 zero");

      // R7: field placement after restore
      for (int k = 0; k < NP; k++) begin
         n = 26'h000_003f;
         drive(mk_pc(k, 0), scramble(n, k), 1'b0, n, "R7 funct field");
         n = 26'h000_07c0;
         drive(mk_pc(k, 0), scramble(n, k), 1'b0, n, "R7 shamt field");
         n = 26'h000_a5c3;
         drive(mk_pc(k, 0), scramble(n, k), 1'b0, n, "R7 immediate field");
      end

      // drain
      repeat (4) @(posedge clk);
      mon_en = 1'b0;

      // R2: new value only after the edge
      @(negedge clk);
      last = opnd_out;
      n = 26'h155_5555 ^ last;
      pc = mk_pc(1, 0); opnd_in = scramble(n, 1); pass_thru = 1'b0;
      #3;
      check(opnd_out, last, "R2 before edge");
      @(posedge clk); #2;
      check(opnd_out, n, "R2 after edge");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule